// File: doc/BRIEF.md
# Asynchronous Receive Sampling Clock Generator

This block produces the receive-side bit timing for an asynchronous serial line. A base timing clock arrives as a one-cycle enable (`tclk_fall_i`) in the system clock domain, and each enable stands for one falling edge of that clock. While the line is idle the block watches the synchronized serial input at every enable. When it sees a falling edge, it locks a bit-period counter to that edge and drives a sampling clock whose rising edge falls near the centre of each bit.

Each bit period is 16 or 8 enables long, chosen by `div8_i`. Within a bit the sampling clock is low for most of the first half and high for the rest, so its duty cycle is not 50%. The start bit is checked twice. A short glitch is dropped at the second enable. A start bit that is not low at mid-bit ends the frame quietly, and no output reports it.

Data bits are collected LSB first into a word. The word is presented with a one-cycle valid pulse once the final stop bit has been sampled. Data width, parity slot and stop count are taken from the configuration inputs at the moment a start bit is detected.

Top module: `rx_sclk_gen`

## Requirements
- R1: With `div8_i`=0, each bit period lasts 16 enables. Within a bit, `sclk_o` is low for exactly 6 enables and high for 10.
- R2: With `div8_i`=1, each bit period lasts 8 enables. Within a bit, `sclk_o` is low for exactly 2 enables and high for 6.
- R3: While idle, a start is detected at the first enable where the synchronized input is low and was high at the previous enable. That enable is edge 1. `sclk_o` falls at the enable of edge 2.
- R4: `sclk_o` rises at edge 8 (edge 4 in divide-by-8 mode) of every bit, the start bit included. In the same cycle `smp_o` pulses for one system clock.
- R5: If the input is high again at edge 2 after a start detection, the event is treated as noise. `sclk_o` stays high, no `smp_o` pulse follows, and the block returns to idle.
- R6: If the start bit reads high at its mid-bit sample, the block returns to idle without asserting `valid_o`. Its one `smp_o` pulse for that sample still occurs.
- R7: After the final stop bit is sampled, `sclk_o` stays high and `smp_o` stays low until a new start is detected.
- R8: Data bits are placed LSB first: the first data bit after the start bit lands in `word_o[0]`. `valid_o` pulses for one system clock after the last stop bit is sampled, and `word_o` holds the word from that pulse onward.
- R9: A frame is 1 start bit, `data_bits_i` data bits (1 to DATA_W), one parity slot when `parity_en_i`=1, and 1 stop bit (2 when `two_stop_i`=1). The parity slot is sampled but not stored. Unused upper bits of `word_o` read 0, and `valid_o` does not pulse before the last stop bit.
- R10: Changes to `div8_i`, `data_bits_i`, `parity_en_i` or `two_stop_i` during a frame have no effect until the next start detection.
- R11: While `rst_ni` is low, `sclk_o`=1, `smp_o`=0, `valid_o`=0 and `word_o`=0, and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tclk_fall_i | input | 1 | One-cycle enable marking a falling edge of the base timing clock |
| rxd_i | input | 1 | Serial input, asynchronous, idle high |
| div8_i | input | 1 | Divide select: 0 gives 16 enables per bit, 1 gives 8 |
| data_bits_i | input | $clog2(DATA_W+1) | Number of data bits per frame, from 1 to DATA_W |
| parity_en_i | input | 1 | Adds one parity slot after the data bits |
| two_stop_i | input | 1 | Uses two stop bits instead of one |
| sclk_o | output | 1 | Sampling clock level |
| smp_o | output | 1 | One-cycle strobe for each mid-bit sample |
| word_o | output | DATA_W | Last received word, right aligned |
| valid_o | output | 1 | One-cycle pulse when `word_o` is updated |

## Verification
Two events can fall close together or in the same cycle. The first is the end of one frame: the stop-bit sample returns the block to idle. The second is the start detection of the next frame, which must be caught within half a bit. Back-to-back frames with no idle gap provoke this pairing, and both words are judged by their values and by one valid pulse each. The mid-bit sample strobe and a silent abort also share one cycle. A start bit that rises before its centre provokes this, and the bench expects exactly one strobe, no valid pulse, and a correctly received frame immediately afterwards.

// File: rtl/rx_sclk_pkg.sv
package rx_sclk_pkg;
  localparam int PH_W = 4;

  typedef enum logic {ST_IDLE, ST_RUN} rx_state_e;

  localparam logic [PH_W-1:0] PH_FALL     = 4'd1;
  localparam logic [PH_W-1:0] PH_MID_D16  = 4'd7;
  localparam logic [PH_W-1:0] PH_MID_D8   = 4'd3;
  localparam logic [PH_W-1:0] PH_LAST_D16 = 4'd15;
  localparam logic [PH_W-1:0] PH_LAST_D8  = 4'd7;
endpackage

// File: rtl/rx_sclk_sync.sv
module rx_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // line idles high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_sclk_timer.sv
module rx_sclk_timer
  import rx_sclk_pkg::*;
#(
  parameter int DB_W  = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tclk_fall_i,
  input  logic             rxd_s_i,
  input  logic             div8_i,
  input  logic [DB_W-1:0]  data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  output logic             sclk_o,
  output logic             smp_o,
  output logic             smp_bit_o,
  output logic [IDX_W-1:0] smp_idx_o,
  output logic             frame_start_o,
  output logic [IDX_W-1:0] last_idx_o,
  output logic [DB_W-1:0]  dbits_o
);
  rx_state_e        state_q;
  logic [PH_W-1:0]  ph_q, ph_nxt, ph_last, ph_mid;
  logic [IDX_W-1:0] idx_q, idx_nxt, last_q, sidx_q;
  logic [DB_W-1:0]  dbits_q;
  logic             div8_q, prev_q, sclk_q, smp_q, bit_q, start_q;
  logic             start_bad;

  always_comb begin
    ph_last   = div8_q ? PH_LAST_D8 : PH_LAST_D16;
    ph_mid    = div8_q ? PH_MID_D8  : PH_MID_D16;
    ph_nxt    = (ph_q == ph_last) ? '0 : ph_q + 1'b1;
    idx_nxt   = (ph_q == ph_last) ? idx_q + 1'b1 : idx_q;
    start_bad = (idx_nxt == '0) && rxd_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      sidx_q  <= '0;
      dbits_q <= '0;
      div8_q  <= 1'b0;
      prev_q  <= 1'b1;
      sclk_q  <= 1'b1;
      smp_q   <= 1'b0;
      bit_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      smp_q   <= 1'b0;
      start_q <= 1'b0;
      if (tclk_fall_i) begin
        prev_q <= rxd_s_i;
        case (state_q)
          ST_IDLE: begin
            if (prev_q && !rxd_s_i) begin
              // edge 1: lock phase and configuration
              state_q <= ST_RUN;
              ph_q    <= '0;
              idx_q   <= '0;
              div8_q  <= div8_i;
              dbits_q <= data_bits_i;
              last_q  <= IDX_W'(data_bits_i) + IDX_W'(parity_en_i)
                       + IDX_W'(1) + IDX_W'(two_stop_i);
              start_q <= 1'b1;
            end
          end
          default: begin
            ph_q  <= ph_nxt;
            idx_q <= idx_nxt;
            if (ph_nxt == PH_FALL) begin
              if (start_bad) state_q <= ST_IDLE;  // glitch
              else           sclk_q  <= 1'b0;
            end else if (ph_nxt == ph_mid) begin
              sclk_q <= 1'b1;
              smp_q  <= 1'b1;
              bit_q  <= rxd_s_i;
              sidx_q <= idx_nxt;
              if (start_bad || idx_nxt == last_q) state_q <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign sclk_o        = sclk_q;
  assign smp_o         = smp_q;
  assign smp_bit_o     = bit_q;
  assign smp_idx_o     = sidx_q;
  assign frame_start_o = start_q;
  assign last_idx_o    = last_q;
  assign dbits_o       = dbits_q;
endmodule

// File: rtl/rx_sclk_shift.sv
module rx_sclk_shift #(
  parameter int DATA_W = 8,
  parameter int DB_W   = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              smp_i,
  input  logic              smp_bit_i,
  input  logic [IDX_W-1:0]  smp_idx_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  input  logic [DB_W-1:0]   dbits_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] acc_q, word_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (frame_start_i) acc_q <= '0;
      for (int k = 0; k < DATA_W; k++) begin
        if (smp_i && smp_idx_i == IDX_W'(k + 1) && DB_W'(k) < dbits_i)
          acc_q[k] <= smp_bit_i;
      end
      if (smp_i && smp_idx_i != '0 && smp_idx_i == last_idx_i) begin
        word_q  <= acc_q;
        valid_q <= 1'b1;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rx_sclk_gen.sv
module rx_sclk_gen #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tclk_fall_i,
  input  logic                        rxd_i,
  input  logic                        div8_i,
  input  logic [$clog2(DATA_W+1)-1:0] data_bits_i,
  input  logic                        parity_en_i,
  input  logic                        two_stop_i,
  output logic                        sclk_o,
  output logic                        smp_o,
  output logic [DATA_W-1:0]           word_o,
  output logic                        valid_o
);
  localparam int DB_W  = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W + 4);

  logic             rxd_s, smp_bit, frame_start;
  logic [IDX_W-1:0] smp_idx, last_idx;
  logic [DB_W-1:0]  dbits;

  rx_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_sclk_timer #(.DB_W(DB_W), .IDX_W(IDX_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tclk_fall_i  (tclk_fall_i),
    .rxd_s_i      (rxd_s),
    .div8_i       (div8_i),
    .data_bits_i  (data_bits_i),
    .parity_en_i  (parity_en_i),
    .two_stop_i   (two_stop_i),
    .sclk_o       (sclk_o),
    .smp_o        (smp_o),
    .smp_bit_o    (smp_bit),
    .smp_idx_o    (smp_idx),
    .frame_start_o(frame_start),
    .last_idx_o   (last_idx),
    .dbits_o      (dbits)
  );

  rx_sclk_shift #(.DATA_W(DATA_W), .DB_W(DB_W), .IDX_W(IDX_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start),
    .smp_i        (smp_o),
    .smp_bit_i    (smp_bit),
    .smp_idx_i    (smp_idx),
    .last_idx_i   (last_idx),
    .dbits_i      (dbits),
    .word_o       (word_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/rx_sclk_chk.sv
module rx_sclk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tclk_fall_i,
  input logic sclk_o,
  input logic smp_o,
  input logic valid_o
);
  // R4: each rising edge of the sampling clock carries a strobe
  a_r4_rise_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> smp_o);

  // R4: strobe only while the sampling clock is high
  a_r4_strobe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |-> sclk_o);

  // R3: sampling clock moves only on a base clock edge
  a_r3_sclk_on_tclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(tclk_fall_i));

  // R4: strobes are produced by base clock edges
  a_r4_strobe_on_tclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |-> $past(tclk_fall_i));

  // R8: valid follows a sample strobe and lasts one cycle
  a_r8_valid_after_smp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(smp_o));

  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R11: idle outputs while in reset
  always @(negedge clk_i) begin
    if (!rst_ni) a_r11_reset_idle: assert (sclk_o && !smp_o && !valid_o);
  end
endmodule

bind rx_sclk_gen rx_sclk_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tclk_fall_i(tclk_fall_i),
  .sclk_o     (sclk_o),
  .smp_o      (smp_o),
  .valid_o    (valid_o)
);

// File: tb/tb_rx_sclk_gen.sv
`timescale 1ns/1ps
module tb_rx_sclk_gen;
  localparam int DATA_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tclk_fall_i = 1'b0;
  logic             rxd_i = 1'b1;
  logic             div8_i = 1'b0;
  logic [3:0]       data_bits_i = 4'd8;
  logic             parity_en_i = 1'b0;
  logic             two_stop_i = 1'b0;
  logic             sclk_o, smp_o, valid_o;
  logic [DATA_W-1:0] word_o;

  rx_sclk_gen #(.DATA_W(DATA_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  int tick_cnt = 0;
  always @(negedge clk_i) begin
    tick_cnt++;
    tclk_fall_i <= (tick_cnt % 4 == 0);
  end

  int total = 0, fails = 0, vcount = 0;
  logic [DATA_W-1:0] vlog [16];
  always @(negedge clk_i) if (valid_o) begin
    vlog[vcount % 16] = word_o;
    vcount++;
  end

  int lowcnt [32], smpcnt [32], vat [32];
  int tail_low, tail_smp, chg_at = -1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step_en();
    @(posedge clk_i iff tclk_fall_i);
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] mkframe(input logic [7:0] d, input int db,
                                          input bit par, input bit st2, output int n);
    logic [31:0] f = '1;
    bit p = 0;
    n = 0;
    f[n++] = 1'b0;
    for (int i = 0; i < db; i++) begin f[n++] = d[i]; p ^= d[i]; end
    if (par) f[n++] = p;
    f[n++] = 1'b1;
    if (st2) f[n++] = 1'b1;
    return f;
  endfunction

  task automatic drive(input logic [31:0] bits, input int n, input int per, input int tail);
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) begin div8_i = ~div8_i; data_bits_i = 4'd5; end
      rxd_i = bits[i];
      lowcnt[i] = 0; smpcnt[i] = 0;
      repeat (per) begin
        step_en();
        if (!sclk_o) lowcnt[i]++;
        if (smp_o) smpcnt[i]++;
      end
      vat[i] = vcount;
    end
    rxd_i = 1'b1;
    tail_low = 0; tail_smp = 0;
    repeat (tail) begin
      step_en();
      if (!sclk_o) tail_low++;
      if (smp_o) tail_smp++;
    end
  endtask

  task automatic cfg(input bit d8, input int db, input bit par, input bit st2);
    div8_i = d8; data_bits_i = 4'(db); parity_en_i = par; two_stop_i = st2;
  endtask

  task automatic t_reset();
    chk(sclk_o == 1'b1, "R11 sclk", sclk_o, 1);
    chk(smp_o == 1'b0, "R11 smp", smp_o, 0);
    chk(valid_o == 1'b0, "R11 valid", valid_o, 0);
    chk(word_o == '0, "R11 word", word_o, 0);
  endtask

  task automatic t_div16();
    int n, v0, bad_low, bad_smp;
    logic [31:0] f;
    cfg(0, 8, 0, 0);
    f = mkframe(8'hA5, 8, 0, 0, n);
    v0 = vcount;
    drive(f, n, 16, 40);
    bad_low = 0; bad_smp = 0;
    for (int i = 0; i < n; i++) begin
      if (lowcnt[i] != 6) bad_low++;
      if (smpcnt[i] != 1) bad_smp++;
    end
    chk(bad_low == 0, "R1 low 6 of 16 per bit", bad_low, 0);
    chk(bad_smp == 0, "R4 one strobe per bit", bad_smp, 0);
    chk(vat[n-2] == v0, "R9 no early valid", vat[n-2], v0);
    chk(vcount == v0 + 1, "R8 one valid", vcount, v0 + 1);
    chk(word_o == 8'hA5, "R8 lsb first word", word_o, 8'hA5);
    chk(tail_low == 0 && tail_smp == 0, "R7 idle high after stop", tail_low + tail_smp, 0);
  endtask

  task automatic t_div8();
    int n, v0, bad_low, s;
    logic [31:0] f;
    cfg(1, 8, 1, 1);
    f = mkframe(8'h3C, 8, 1, 1, n);
    v0 = vcount;
    drive(f, n, 8, 24);
    bad_low = 0; s = 0;
    for (int i = 0; i < n; i++) begin
      if (lowcnt[i] != 2) bad_low++;
      s += smpcnt[i];
    end
    chk(bad_low == 0, "R2 low 2 of 8 per bit", bad_low, 0);
    chk(s == 12, "R9 strobes parity two stop", s, 12);
    chk(vat[n-2] == v0 && vcount == v0 + 1, "R9 valid after last stop", vcount - v0, 1);
    chk(word_o == 8'h3C, "R8 word div8", word_o, 8'h3C);
  endtask

  task automatic t_short();
    int n;
    logic [31:0] f;
    cfg(0, 5, 0, 0);
    f = mkframe(8'hF5, 5, 0, 0, n);
    drive(f, n, 16, 20);
    chk(word_o == 8'h15, "R9 five bit word upper zero", word_o, 8'h15);
  endtask

  task automatic t_noise();
    int lows = 0, smps = 0, v0, n;
    logic [31:0] f;
    cfg(0, 8, 0, 0);
    v0 = vcount;
    rxd_i = 1'b0;
    step_en();
    chk(sclk_o == 1'b1, "R3 sclk high at edge 1", sclk_o, 1);
    rxd_i = 1'b1;
    repeat (30) begin
      step_en();
      if (!sclk_o) lows++;
      if (smp_o) smps++;
    end
    chk(lows == 0 && smps == 0, "R5 glitch rejected", lows + smps, 0);
    chk(vcount == v0, "R5 no valid", vcount, v0);
    f = mkframe(8'h5A, 8, 0, 0, n);
    drive(f, n, 16, 20);
    chk(word_o == 8'h5A, "R5 frame after glitch", word_o, 8'h5A);
  endtask

  task automatic t_abort();
    int lows = 0, smps = 0, v0, n;
    logic [31:0] f;
    cfg(0, 8, 0, 0);
    v0 = vcount;
    rxd_i = 1'b0;
    step_en();
    step_en();
    chk(sclk_o == 1'b0, "R3 sclk low at edge 2", sclk_o, 0);
    if (!sclk_o) lows++;
    repeat (2) begin step_en(); if (!sclk_o) lows++; end
    rxd_i = 1'b1;
    repeat (40) begin
      step_en();
      if (!sclk_o) lows++;
      if (smp_o) smps++;
    end
    chk(lows == 6 && smps == 1, "R6 single strobe then stop", lows * 16 + smps, 6 * 16 + 1);
    chk(vcount == v0 && sclk_o, "R6 silent abort", vcount - v0, 0);
    f = mkframe(8'hC3, 8, 0, 0, n);
    drive(f, n, 16, 20);
    chk(word_o == 8'hC3, "R6 frame after abort", word_o, 8'hC3);
  endtask

  task automatic t_cfg_hold();
    int n, bad_low = 0;
    logic [31:0] f;
    cfg(0, 8, 0, 0);
    f = mkframe(8'h96, 8, 0, 0, n);
    chg_at = 2;
    drive(f, n, 16, 20);
    chg_at = -1;
    for (int i = 0; i < n; i++) if (lowcnt[i] != 6) bad_low++;
    chk(bad_low == 0, "R10 divider held mid frame", bad_low, 0);
    chk(word_o == 8'h96, "R10 width held mid frame", word_o, 8'h96);
    cfg(0, 8, 0, 0);
  endtask

  task automatic t_b2b();
    int n, v0;
    logic [31:0] f1, f2;
    cfg(0, 8, 0, 0);
    v0 = vcount;
    f1 = mkframe(8'h81, 8, 0, 0, n);
    drive(f1, n, 16, 0);
    f2 = mkframe(8'h7E, 8, 0, 0, n);
    drive(f2, n, 16, 20);
    chk(vcount == v0 + 2, "R3 back to back two valids", vcount - v0, 2);
    chk(vlog[v0 % 16] == 8'h81, "R8 first b2b word", vlog[v0 % 16], 8'h81);
    chk(vlog[(v0 + 1) % 16] == 8'h7E, "R8 second b2b word", vlog[(v0 + 1) % 16], 8'h7E);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (10) step_en();
    t_div16();
    t_div8();
    t_short();
    t_noise();
    t_abort();
    t_cfg_hold();
    t_b2b();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule